// File: doc/BRIEF.md
# Register Update Unit

This block is the out-of-order core of a small superscalar back end. It is a circular window of in-flight instructions that is filled in program order, lets instructions leave for execution in any order once their operands are present, and retires them in program order again. One structure serves three jobs: it holds waiting instructions like a reservation station, it snoops the result bus to forward values to waiting operands, and it keeps program order for retirement like a reorder buffer.

A decoder presents one instruction per cycle with a unit selector, a destination register and two source registers. A rename table inside the block records, for every architectural register, the window slot of its youngest in-flight producer. A source with no in-flight producer reads the block's architectural register file. A source whose producer has already finished copies the finished value. A source whose producer is still running records that slot number as a tag. The slot number of each instruction is its destination tag. External execution units receive issued instructions and later return a result with the tag of its slot on the single result bus. When the oldest instruction has its result, it writes the register file and leaves the window.

Top module: `ruu_core`

## Requirements
- R1: A dispatch is accepted when `disp_valid` is high and `disp_ready` is high. It takes the slot shown on `disp_tag`. Slots are handed out in ascending order modulo DEPTH, starting at 0 after reset.
- R2: `disp_ready` is low exactly when DEPTH instructions are in flight. A dispatch attempted while it is low has no effect: no slot is taken and the tag is not advanced.
- R3: A source register with no in-flight producer takes the architectural register file value. That value is zero after reset and changes only through commits.
- R4: A source whose producer is in flight takes the producer's result. If the producer has already finished, the value is copied at dispatch. Otherwise the value is captured when a result bus beat carries the producer's tag. One beat can satisfy any number of waiting sources in the same cycle.
- R5: When a result bus beat carries the producer's tag in the same cycle that a dependent instruction is dispatched, that dispatching instruction captures the value.
- R6: `iss_valid` is high only for an entry that has not yet issued and whose two sources are both ready. Its unit (`iss_fu`, with unit number k free when `fu_free[k]` is 1) must be free, and `bus_slot_free` must be high. Each entry issues once. `iss_opa` and `iss_opb` carry its first and second source values.
- R7: Among the entries that may issue, the one nearest the oldest entry is chosen.
- R8: `cmt_valid` is high only when the oldest in-flight entry has received its result. It then shows that entry's tag, destination and result, and the entry is freed at that clock edge. Retirement follows dispatch order.
- R9: A dispatch and a commit in the same cycle both take effect.
- R10: A commit clears a register's rename mapping only if the committing entry is still that register's youngest producer. A later reader of a register with a younger producer in flight waits for that producer.
- R11: After reset the window is empty: `disp_ready` is 1, `disp_tag` is 0, `iss_valid` is 0 and `cmt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_fu | input | FW | Unit number needed by the instruction |
| disp_dst | input | RW | Destination architectural register |
| disp_src_a | input | RW | First source register |
| disp_src_b | input | RW | Second source register |
| disp_ready | output | 1 | Window has a free slot |
| disp_tag | output | TW | Slot given to an accepted dispatch |
| res_valid | input | 1 | Result bus beat valid |
| res_tag | input | TW | Slot of the producing entry |
| res_data | input | DW | Result value |
| fu_free | input | NFU | One bit per unit, 1 when the unit can accept work |
| bus_slot_free | input | 1 | A future result bus slot can be reserved |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_tag | output | TW | Slot of the issuing entry |
| iss_fu | output | FW | Unit of the issuing entry |
| iss_opa | output | DW | First operand value |
| iss_opb | output | DW | Second operand value |
| cmt_valid | output | 1 | Oldest entry retires this cycle |
| cmt_tag | output | TW | Slot of the retiring entry |
| cmt_reg | output | RW | Destination register written |
| cmt_data | output | DW | Value written to the register file |

## Verification
Two pairings can land in one cycle and are the ones most likely to break. The first is a dispatch whose producer broadcasts on the result bus in that very cycle, which is easy to drop because the entry is being written while the snoop runs. The second is a dispatch together with a commit, which moves both pointers and may touch the same rename mapping. The bench produces both by keeping the window partly full with short-latency results and a dispatch attempt on most cycles. Its model tracks, for each source, whether the value came from the register file, a finished producer, a later beat or a same-cycle beat. The issued operands are then compared under the matching requirement, and commit fields seen during a dispatch cycle are judged against R9.

// File: rtl/ruu_pkg.sv
package ruu_pkg;
   // index width with a floor of one bit
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
   localparam int NSRC = 2;
endpackage

// File: rtl/ruu_rename.sv
module ruu_rename #(
   parameter int NREG = 8,
   parameter int RW   = 3,
   parameter int TW   = 3
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0][RW-1:0]   rd_reg,
   output logic [1:0]           hit,
   output logic [1:0][TW-1:0]   hit_tag,
   input  logic                 set_en,
   input  logic [RW-1:0]        set_reg,
   input  logic [TW-1:0]        set_tag,
   input  logic                 clr_en,
   input  logic [RW-1:0]        clr_reg,
   input  logic [TW-1:0]        clr_tag
);
   logic [NREG-1:0] map_v;
   logic [TW-1:0]   map_t [NREG];

   always_comb begin
      for (int s = 0; s < 2; s++) begin
         hit[s]     = map_v[rd_reg[s]];
         hit_tag[s] = map_t[rd_reg[s]];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_v <= '0;
         for (int r = 0; r < NREG; r++) map_t[r] <= '0;
      end else begin
         // retire only drops a mapping still owned by the retiring slot
         if (clr_en && map_v[clr_reg] && map_t[clr_reg] == clr_tag)
            map_v[clr_reg] <= 1'b0;
         // a new producer always wins over a same-cycle clear
         if (set_en) begin
            map_v[set_reg] <= 1'b1;
            map_t[set_reg] <= set_tag;
         end
      end
   end
endmodule

// File: rtl/ruu_arf.sv
module ruu_arf #(
   parameter int NREG = 8,
   parameter int RW   = 3,
   parameter int DW   = 16
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0][RW-1:0]   rd_reg,
   output logic [1:0][DW-1:0]   rd_data,
   input  logic                 we,
   input  logic [RW-1:0]        wr_reg,
   input  logic [DW-1:0]        wr_data
);
   logic [DW-1:0] regs [NREG];

   always_comb begin
      for (int s = 0; s < 2; s++) rd_data[s] = regs[rd_reg[s]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) regs[r] <= '0;
      end else if (we) begin
         regs[wr_reg] <= wr_data;
      end
   end
endmodule

// File: rtl/ruu_pick.sv
module ruu_pick #(
   parameter int DEPTH = 8,
   parameter int TW    = 3
)(
   input  logic [DEPTH-1:0] cand,
   input  logic [TW-1:0]    head,
   output logic             found,
   output logic [TW-1:0]    idx
);
   logic [TW-1:0] p;

   // walk from the oldest slot so the first hit is the oldest ready one
   always_comb begin
      found = 1'b0;
      idx   = '0;
      p     = '0;
      for (int k = 0; k < DEPTH; k++) begin
         p = head + TW'(k);
         if (!found && cand[p]) begin
            found = 1'b1;
            idx   = p;
         end
      end
   end
endmodule

// File: rtl/ruu_core.sv
module ruu_core import ruu_pkg::*; #(
   parameter  int DEPTH = 8,
   parameter  int DW    = 16,
   parameter  int NREG  = 8,
   parameter  int NFU   = 2,
   localparam int TW    = idx_w(DEPTH),
   localparam int RW    = idx_w(NREG),
   localparam int FW    = idx_w(NFU)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            disp_valid,
   input  logic [FW-1:0]   disp_fu,
   input  logic [RW-1:0]   disp_dst,
   input  logic [RW-1:0]   disp_src_a,
   input  logic [RW-1:0]   disp_src_b,
   output logic            disp_ready,
   output logic [TW-1:0]   disp_tag,
   input  logic            res_valid,
   input  logic [TW-1:0]   res_tag,
   input  logic [DW-1:0]   res_data,
   input  logic [NFU-1:0]  fu_free,
   input  logic            bus_slot_free,
   output logic            iss_valid,
   output logic [TW-1:0]   iss_tag,
   output logic [FW-1:0]   iss_fu,
   output logic [DW-1:0]   iss_opa,
   output logic [DW-1:0]   iss_opb,
   output logic            cmt_valid,
   output logic [TW-1:0]   cmt_tag,
   output logic [RW-1:0]   cmt_reg,
   output logic [DW-1:0]   cmt_data
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ruu_core: DEPTH must be a power of two of at least 2");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("ruu_core: NREG must be a power of two of at least 2");
   end
   if (NFU < 1 || NFU > (1 << FW)) begin : g_bad_nfu
      $error("ruu_core: NFU out of range");
   end

   typedef struct packed {
      logic                 vld;
      logic                 iss;
      logic                 done;
      logic [FW-1:0]        fu;
      logic [RW-1:0]        dst;
      logic [NSRC-1:0]      rdy;
      logic [NSRC-1:0][TW-1:0] tag;
      logic [NSRC-1:0][DW-1:0] opd;
      logic [DW-1:0]        res;
   } ent_t;

   ent_t             ent [DEPTH];
   logic [DEPTH-1:0] cand;
   logic [TW-1:0]    head_q, tail_q;
   logic             full_q;
   logic             do_disp, do_cmt;

   logic [1:0][RW-1:0] src_reg;
   logic [1:0]         ren_hit;
   logic [1:0][TW-1:0] ren_tag;
   logic [1:0][DW-1:0] arf_val;
   logic [1:0]         new_rdy;
   logic [1:0][DW-1:0] new_opd;

   assign do_disp = disp_valid && !full_q;
   assign do_cmt  = ent[head_q].vld && ent[head_q].done;
   assign src_reg = {disp_src_b, disp_src_a};

   ruu_rename #(.NREG(NREG), .RW(RW), .TW(TW)) u_ren (
      .clk(clk), .rst_n(rst_n), .rd_reg(src_reg), .hit(ren_hit), .hit_tag(ren_tag),
      .set_en(do_disp), .set_reg(disp_dst), .set_tag(tail_q),
      .clr_en(do_cmt), .clr_reg(ent[head_q].dst), .clr_tag(head_q));

   ruu_arf #(.NREG(NREG), .RW(RW), .DW(DW)) u_arf (
      .clk(clk), .rst_n(rst_n), .rd_reg(src_reg), .rd_data(arf_val),
      .we(do_cmt), .wr_reg(ent[head_q].dst), .wr_data(ent[head_q].res));

   // operand source for a dispatching instruction
   always_comb begin
      for (int s = 0; s < 2; s++) begin
         if (!ren_hit[s]) begin
            new_rdy[s] = 1'b1;
            new_opd[s] = arf_val[s];
         end else if (ent[ren_tag[s]].done) begin
            new_rdy[s] = 1'b1;
            new_opd[s] = ent[ren_tag[s]].res;
         end else if (res_valid && res_tag == ren_tag[s]) begin
            new_rdy[s] = 1'b1;
            new_opd[s] = res_data;
         end else begin
            new_rdy[s] = 1'b0;
            new_opd[s] = '0;
         end
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      ent_t q;
      logic alloc, free_e, iss_e, res_e;
      assign alloc  = do_disp && tail_q == TW'(g);
      assign free_e = do_cmt && head_q == TW'(g);
      assign iss_e  = iss_valid && iss_tag == TW'(g);
      assign res_e  = res_valid && res_tag == TW'(g);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (alloc) begin
            q.vld  <= 1'b1;
            q.iss  <= 1'b0;
            q.done <= 1'b0;
            q.fu   <= disp_fu;
            q.dst  <= disp_dst;
            q.rdy  <= new_rdy;
            q.tag  <= ren_tag;
            q.opd  <= new_opd;
            q.res  <= '0;
         end else begin
            if (free_e) q.vld <= 1'b0;
            if (iss_e)  q.iss <= 1'b1;
            if (res_e && q.vld) begin
               q.done <= 1'b1;
               q.res  <= res_data;
            end
            // one comparator per source against the single result bus
            for (int s = 0; s < NSRC; s++) begin
               if (res_valid && q.vld && !q.rdy[s] && q.tag[s] == res_tag) begin
                  q.rdy[s] <= 1'b1;
                  q.opd[s] <= res_data;
               end
            end
         end
      end

      assign ent[g]  = q;
      assign cand[g] = q.vld && !q.iss && (&q.rdy) && fu_free[q.fu] && bus_slot_free;
   end

   ruu_pick #(.DEPTH(DEPTH), .TW(TW)) u_pick (
      .cand(cand), .head(head_q), .found(iss_valid), .idx(iss_tag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (do_disp) tail_q <= tail_q + TW'(1);
         if (do_cmt)  head_q <= head_q + TW'(1);
         if (do_disp && !do_cmt && (tail_q + TW'(1)) == head_q) full_q <= 1'b1;
         else if (do_cmt && !do_disp) full_q <= 1'b0;
      end
   end

   assign disp_ready = !full_q;
   assign disp_tag   = tail_q;
   assign iss_fu     = ent[iss_tag].fu;
   assign iss_opa    = ent[iss_tag].opd[0];
   assign iss_opb    = ent[iss_tag].opd[1];
   assign cmt_valid  = do_cmt;
   assign cmt_tag    = head_q;
   assign cmt_reg    = ent[head_q].dst;
   assign cmt_data   = ent[head_q].res;
endmodule

// File: rtl/ruu_core_chk.sv
module ruu_core_chk #(
   parameter  int DEPTH = 8,
   parameter  int NFU   = 2,
   localparam int TW    = ruu_pkg::idx_w(DEPTH),
   localparam int FW    = ruu_pkg::idx_w(NFU)
)(
   input logic           clk,
   input logic           rst_n,
   input logic           disp_valid,
   input logic           disp_ready,
   input logic [TW-1:0]  disp_tag,
   input logic [NFU-1:0] fu_free,
   input logic           bus_slot_free,
   input logic           iss_valid,
   input logic [FW-1:0]  iss_fu,
   input logic           res_valid,
   input logic [TW-1:0]  res_tag,
   input logic           cmt_valid,
   input logic [TW-1:0]  cmt_tag
);
   int               occ;
   logic [TW-1:0]    dctr, cctr;
   logic [DEPTH-1:0] got_res;
   logic             dfire;

   assign dfire = disp_valid && disp_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ     <= 0;
         dctr    <= '0;
         cctr    <= '0;
         got_res <= '0;
      end else begin
         occ <= occ + (dfire ? 1 : 0) - (cmt_valid ? 1 : 0);
         if (dfire)     dctr <= dctr + TW'(1);
         if (cmt_valid) cctr <= cctr + TW'(1);
         if (res_valid) got_res[res_tag] <= 1'b1;
         if (cmt_valid) got_res[cmt_tag] <= 1'b0;
         if (dfire)     got_res[disp_tag] <= 1'b0;
      end
   end

   p_alloc_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dfire |-> disp_tag == dctr);
   p_stall_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      disp_ready == (occ != DEPTH));
   p_issue_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (fu_free[iss_fu] && bus_slot_free));
   p_commit_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid |-> (cmt_tag == cctr && got_res[cmt_tag]));
   p_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == 0) |-> (!cmt_valid && !iss_valid));
endmodule

bind ruu_core ruu_core_chk #(.DEPTH(DEPTH), .NFU(NFU)) u_chk (
   .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
   .disp_tag(disp_tag), .fu_free(fu_free), .bus_slot_free(bus_slot_free),
   .iss_valid(iss_valid), .iss_fu(iss_fu), .res_valid(res_valid), .res_tag(res_tag),
   .cmt_valid(cmt_valid), .cmt_tag(cmt_tag));

// File: tb/sim_ruu_core.sv
module sim_ruu_core;
   localparam int DEPTH = 8, DW = 16, NREG = 8, NFU = 2;
   localparam int TW = 3, RW = 3, FW = 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic disp_valid = 1'b0, res_valid = 1'b0, bus_slot_free = 1'b0;
   logic [FW-1:0] disp_fu = '0;
   logic [RW-1:0] disp_dst = '0, disp_src_a = '0, disp_src_b = '0;
   logic [TW-1:0] res_tag = '0;
   logic [DW-1:0] res_data = '0;
   logic [NFU-1:0] fu_free = '0;
   logic disp_ready, iss_valid, cmt_valid;
   logic [TW-1:0] disp_tag, iss_tag, cmt_tag;
   logic [FW-1:0] iss_fu;
   logic [DW-1:0] iss_opa, iss_opb, cmt_data;
   logic [RW-1:0] cmt_reg;

   always #4 clk = ~clk;

   ruu_core #(.DEPTH(DEPTH), .DW(DW), .NREG(NREG), .NFU(NFU)) u0 (.*);

   typedef struct {
      int tag; int fu; int dst;
      bit rdy[2]; int ptag[2]; int val[2]; int kind[2];
      bit iss; bit done; int res;
   } rec_t;
   typedef struct { int tag; int due; int data; } pend_t;

   rec_t  q[$];
   pend_t pend[$];
   int    regs[NREG];
   int    ntail = 0, cyc = 0, n_cmp = 0, n_bad = 0;
   bit    last_fire, finished = 0;
   string extra = "";

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s%s %s actual=%0h expected=%0h (cycle %0d)", extra, req, what, act, exp, cyc);
      end
   endtask

   function automatic string kname(input int k);
      return (k == 0) ? "R3" : (k == 2) ? "R5" : "R4";
   endfunction

   task automatic step(input bit dv, input int fu, input int dst, input int sa, input int sb,
                       input logic [NFU-1:0] ff, input bit slot);
      int ei, pi, rt, rd; bit rv, ecv, dfire; rec_t nr; int srcs[2];
      @(negedge clk);
      disp_valid = dv; disp_fu = FW'(fu); disp_dst = RW'(dst);
      disp_src_a = RW'(sa); disp_src_b = RW'(sb); fu_free = ff; bus_slot_free = slot;
      pi = -1;
      for (int i = 0; i < pend.size(); i++)
         if (pend[i].due <= cyc && (pi < 0 || pend[i].due < pend[pi].due)) pi = i;
      rv = (pi >= 0); rt = rv ? pend[pi].tag : 0; rd = rv ? pend[pi].data : 0;
      if (rv) pend.delete(pi);
      res_valid = rv; res_tag = TW'(rt); res_data = DW'(rd);
      #1;
      // expected outputs from the pre-edge model state
      ei = -1;
      for (int i = 0; i < q.size(); i++)
         if (ei < 0 && !q[i].iss && q[i].rdy[0] && q[i].rdy[1] && ff[q[i].fu] && slot) ei = i;
      ecv   = q.size() > 0 && q[0].done;
      dfire = dv && q.size() < DEPTH;
      chk("R2", "disp_ready", disp_ready, q.size() < DEPTH);
      chk("R1", "disp_tag", disp_tag, ntail);
      chk("R6", "iss_valid", iss_valid, ei >= 0);
      if (ei >= 0 && iss_valid) begin
         chk("R7", "iss_tag", iss_tag, q[ei].tag);
         chk("R6", "iss_fu", iss_fu, q[ei].fu);
         chk(kname(q[ei].kind[0]), "iss_opa", iss_opa, q[ei].val[0]);
         chk(kname(q[ei].kind[1]), "iss_opb", iss_opb, q[ei].val[1]);
      end
      chk("R8", "cmt_valid", cmt_valid, ecv);
      if (ecv && cmt_valid) begin
         chk(dfire ? "R9" : "R8", "cmt_tag", cmt_tag, q[0].tag);
         chk("R8", "cmt_reg", cmt_reg, q[0].dst);
         chk("R8", "cmt_data", cmt_data, q[0].res);
      end
      // execution units of the bench
      if (ei >= 0) begin
         pend_t p;
         p.tag = q[ei].tag;
         p.due = cyc + ((q[ei].fu == 0) ? 1 : 3);
         p.data = (q[ei].fu == 0) ? ((q[ei].val[0] + q[ei].val[1] + 257 * (q[ei].tag + 1)) & 16'hFFFF)
                                  : (((q[ei].val[0] ^ q[ei].val[1]) + 55 + 5 * q[ei].tag) & 16'hFFFF);
         pend.push_back(p);
      end
      // model update as of the clock edge
      if (dfire) begin
         srcs[0] = sa; srcs[1] = sb;
         nr.tag = ntail; nr.fu = fu; nr.dst = dst; nr.iss = 0; nr.done = 0; nr.res = 0;
         for (int s = 0; s < 2; s++) begin
            int y; y = -1;
            for (int i = 0; i < q.size(); i++) if (q[i].dst == srcs[s]) y = i;
            nr.ptag[s] = 0;
            if (y < 0) begin nr.rdy[s] = 1; nr.val[s] = regs[srcs[s]]; nr.kind[s] = 0; end
            else if (q[y].done) begin nr.rdy[s] = 1; nr.val[s] = q[y].res; nr.kind[s] = 1; end
            else if (rv && rt == q[y].tag) begin nr.rdy[s] = 1; nr.val[s] = rd; nr.kind[s] = 2; end
            else begin nr.rdy[s] = 0; nr.val[s] = 0; nr.ptag[s] = q[y].tag; nr.kind[s] = 1; end
         end
      end
      for (int i = 0; i < q.size(); i++) begin
         if (rv && q[i].tag == rt) begin q[i].done = 1; q[i].res = rd; end
         for (int s = 0; s < 2; s++)
            if (rv && !q[i].rdy[s] && q[i].ptag[s] == rt) begin q[i].rdy[s] = 1; q[i].val[s] = rd; end
      end
      if (ei >= 0) q[ei].iss = 1;
      if (ecv) begin regs[q[0].dst] = q[0].res; void'(q.pop_front()); end
      if (dfire) begin q.push_back(nr); ntail = (ntail + 1) % DEPTH; end
      last_fire = dfire;
      cyc++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int bd[9] = '{1, 1, 2, 3, 1, 4, 5, 6, 7};
      int ba[9] = '{2, 1, 1, 2, 3, 1, 5, 4, 1};
      int bb[9] = '{3, 2, 1, 1, 3, 4, 1, 5, 6};
      int bf[9] = '{0, 1, 0, 0, 1, 0, 0, 1, 0};
      int idx;
      for (int r = 0; r < NREG; r++) regs[r] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R11 reset state
      chk("R11", "reset disp_ready", disp_ready, 1);
      chk("R11", "reset disp_tag", disp_tag, 0);
      chk("R11", "reset iss_valid", iss_valid, 0);
      chk("R11", "reset cmt_valid", cmt_valid, 0);
      // directed fill with units held busy, then release (R2, R10)
      extra = "R10/";
      idx = 0;
      for (int c = 0; c < 60 && idx < 9; c++) begin
         step(1, bf[idx], bd[idx], ba[idx], bb[idx], (c < 11) ? 2'b00 : 2'b11, 1);
         if (last_fire) idx++;
      end
      extra = "";
      // mixed random traffic
      for (int c = 0; c < 4000; c++) begin
         step($urandom_range(0, 9) < 7, $urandom_range(0, NFU - 1), $urandom_range(0, NREG - 1),
              $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1),
              {$urandom_range(0, 9) < 8, $urandom_range(0, 9) < 8}, $urandom_range(0, 9) < 9);
      end
      // drain
      for (int c = 0; c < 500 && (q.size() > 0 || pend.size() > 0); c++) step(0, 0, 0, 0, 0, 2'b11, 1);
      step(0, 0, 0, 0, 0, 2'b11, 1);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule